// File: doc/BRIEF.md
# Arithmetic Logic Unit with Status Flags

This block computes byte- or word-wide arithmetic, logical and decimal-adjust operations and produces the six condition flags that go with them: carry, parity, auxiliary carry, zero, sign and overflow. A caller supplies two operands, an operation code, a width select, an incoming carry and the flag values currently held by the processor. The block returns a result, a flag that says whether the result should be written back, the new flag values and a mask that marks which flags the operation updated.

Flags the operation does not touch are passed through from the prior flag input. Increment and decrement keep the old carry. The logical operations clear carry and overflow. Compare and test update flags only. Complement changes no flag at all. The two decimal adjusts repair the low byte after a packed or unpacked BCD addition, and they use the prior carry and auxiliary flags for this. The datapath itself is combinational. One output register stage with a synchronous active-low reset follows it, so each output appears one clock after its inputs.

Top module: `alu_flags_unit`

## Requirements
- R1: All outputs are registered and appear one clock after their inputs. Reset clears the result, write-enable, flags and mask to zero. The flag vectors use bit 0 for carry, 1 for parity, 2 for auxiliary, 3 for zero, 4 for sign and 5 for overflow. The op codes are 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 INC, 5 DEC, 6 NEG, 7 CMP, 8 AND, 9 OR, 10 XOR, 11 TEST, 12 NOT, 13 DAA, 14 AAA. Code 15 writes nothing, updates no flag and gives a zero result.
- R2: Parity is 1 when bits 7:0 of the result hold an even number of ones. This holds in both widths.
- R3: INC and DEC update auxiliary, zero, sign, parity and overflow, and keep carry at its prior value. Incrementing byte FFh gives 00h with carry unchanged.
- R4: ADC adds the incoming carry. For SUB, SBB and CMP, carry is a borrow: it is 1 when the subtrahend, plus the incoming carry in the case of SBB, exceeds the minuend taken as unsigned values.
- R5: AND, OR, XOR and TEST clear carry and overflow, update parity, sign and zero, and leave auxiliary at its prior value.
- R6: CMP and TEST deassert write-enable. Every other defined op asserts it.
- R7: NOT returns the bitwise complement within the selected width, gives a zero mask and passes every flag through unchanged.
- R8: NEG returns 0 minus the operand. Carry is set for any nonzero operand. Overflow is set when the operand is 80h in byte mode or 8000h in word mode.
- R9: DAA adjusts bits 7:0 of operand A after a packed BCD add and passes bits 15:8 through. Example: 8Eh becomes 94h. It updates every flag except overflow.
- R10: AAA adjusts an unpacked BCD add. It adds 6 to bits 7:0 and 1 to bits 15:8, and sets carry and auxiliary, when the low nibble is above 9 or auxiliary was set; otherwise both flags are cleared. The upper nibble of bits 7:0 is then zeroed. Example: 006Eh becomes 0104h with carry set. Only carry and auxiliary are updated.
- R11: Auxiliary is the carry or borrow out of bit 3. Overflow is the signed overflow at the top bit of the selected width. Zero and sign refer to the selected width. In byte mode, bits 15:8 of an arithmetic or logical result are zero.
- R12: Every flag whose mask bit is 0 equals the prior flag input of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 4 | Operation select (R1 encoding) |
| is_word | input | 1 | 1 selects word width, 0 selects byte width |
| opnd_a | input | DATA_W | Destination or sole operand |
| opnd_b | input | DATA_W | Source operand |
| carry_in | input | 1 | Carry or borrow consumed by ADC and SBB |
| flags_in | input | 6 | Prior flag values |
| res_q | output | DATA_W | Registered result |
| wr_en_q | output | 1 | Registered write-back enable |
| flags_q | output | 6 | Registered updated flags |
| mask_q | output | 6 | Registered flag-update mask |

## Verification
The bench builds the block with its default DATA_W of 16. At this width, word and byte mode differ in where carry, overflow, sign and zero are taken. The same build therefore reaches the byte-wide boundaries (FFh to 00h, 80h negation, borrow out of bit 7) and the word-wide ones (7FFFh overflow, 8000h negation). Parity stays on the low byte in both widths, and the word-mode vectors with a nonzero upper byte show that. The decimal adjusts are byte-only, and these vectors show that the word select does not change them.

// File: rtl/alu_flags_pkg.sv
// Shared op codes, flag bit positions and flag-update masks for the ALU.
// Assumes a six-entry flag vector in the bit order the requirements fix.
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_NEG  = 4'd6,
        OP_CMP  = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_TEST = 4'd11,
        OP_NOT  = 4'd12,
        OP_DAA  = 4'd13,
        OP_AAA  = 4'd14,
        OP_RSVD = 4'd15
    } alu_op_e;

    localparam int FLAG_N = 6;
    localparam int FLG_CF = 0;
    localparam int FLG_PF = 1;
    localparam int FLG_AF = 2;
    localparam int FLG_ZF = 3;
    localparam int FLG_SF = 4;
    localparam int FLG_OF = 5;

    localparam logic [FLAG_N-1:0] MASK_ALL     = 6'b111111;
    localparam logic [FLAG_N-1:0] MASK_KEEP_CF = 6'b111110;
    localparam logic [FLAG_N-1:0] MASK_LOGIC   = 6'b111011;
    localparam logic [FLAG_N-1:0] MASK_DAA     = 6'b011111;
    localparam logic [FLAG_N-1:0] MASK_AAA     = 6'b000101;

endpackage

// File: rtl/alu_addsub.sv
// Shared add/subtract core. It computes a +/- b +/- cin at full width and
// reports carry (borrow for subtract), the carry out of bit 3 and signed
// overflow at the top of the selected width.
// Assumes the caller has zeroed bits above HALF_W in byte mode.
module alu_addsub #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    input  logic              wide,
    output logic [DATA_W-1:0] sum,
    output logic              cf,
    output logic              af,
    output logic              of
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] ext;
    logic            sa, sb, sr;

    // Extended-width add or subtract so the carry of either width is visible.
    always_comb begin
        if (sub) ext = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
        else     ext = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    end

    // Pick carry, sign bits and masked sum for the selected width.
    always_comb begin
        if (wide) begin
            sum = ext[DATA_W-1:0];
            cf  = ext[DATA_W];
            sa  = a[DATA_W-1];
            sb  = b[DATA_W-1];
            sr  = ext[DATA_W-1];
        end else begin
            sum = {{HALF_W{1'b0}}, ext[HALF_W-1:0]};
            cf  = ext[HALF_W];
            sa  = a[HALF_W-1];
            sb  = b[HALF_W-1];
            sr  = ext[HALF_W-1];
        end
    end

    // Nibble carry and signed overflow.
    always_comb begin
        af = a[4] ^ b[4] ^ ext[4];
        if (sub) of = (sa != sb) && (sr != sa);
        else     of = (sa == sb) && (sr != sa);
    end

endmodule

// File: rtl/alu_decimal_adj.sv
// BCD correction after addition: a packed adjust (two digits in the low
// byte) and an unpacked adjust (one digit, with carry into the high byte).
// Assumes HALF_W is 8; only the low and high byte of operand A are used.
module alu_decimal_adj #(
    parameter int HALF_W = 8
) (
    input  logic [HALF_W-1:0]   lo_in,
    input  logic [HALF_W-1:0]   hi_in,
    input  logic                af_in,
    input  logic                cf_in,
    input  logic                unpacked,
    output logic [2*HALF_W-1:0] word_out,
    output logic                cf_out,
    output logic                af_out
);
    localparam logic [HALF_W-1:0] SIX       = HALF_W'(6);
    localparam logic [HALF_W-1:0] SIXTY     = HALF_W'(8'h60);
    localparam logic [HALF_W-1:0] TOP_BCD   = HALF_W'(8'h99);
    localparam logic [3:0]        NINE      = 4'd9;

    logic              nib_fix, byte_fix;
    logic [HALF_W-1:0] step1, packed_lo, unpk_lo, unpk_hi;

    // Decide which corrections apply.
    always_comb begin
        nib_fix  = (lo_in[3:0] > NINE) || af_in;
        byte_fix = (lo_in > TOP_BCD) || cf_in;
    end

    // Apply the corrections for both styles of adjust.
    always_comb begin
        step1     = lo_in + (nib_fix ? SIX : '0);
        packed_lo = step1 + (byte_fix ? SIXTY : '0);
        unpk_lo   = {{(HALF_W-4){1'b0}}, step1[3:0]};
        unpk_hi   = hi_in + {{(HALF_W-1){1'b0}}, nib_fix};
    end

    // Select the adjust style and its flags.
    always_comb begin
        if (unpacked) begin
            word_out = {unpk_hi, unpk_lo};
            cf_out   = nib_fix;
            af_out   = nib_fix;
        end else begin
            word_out = {hi_in, packed_lo};
            cf_out   = byte_fix;
            af_out   = nib_fix;
        end
    end

endmodule

// File: rtl/alu_status.sv
// Result-derived flags: parity of the low byte, and zero and sign at the
// selected width. Assumes DATA_W is even and at least 16.
module alu_status #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] res,
    input  logic              wide,
    output logic              pf,
    output logic              zf,
    output logic              sf
);
    localparam int HALF_W = DATA_W / 2;

    // Even parity of bits 7:0 in either width.
    always_comb pf = ~^res[7:0];

    // Zero and sign at the selected width.
    always_comb begin
        if (wide) begin
            zf = (res == '0);
            sf = res[DATA_W-1];
        end else begin
            zf = (res[HALF_W-1:0] == '0);
            sf = res[HALF_W-1];
        end
    end

endmodule

// File: rtl/alu_flags_unit.sv
// ALU top: decodes the op, drives the add/subtract core, logical ops and
// decimal adjust, merges the new flags with the prior ones under a mask,
// and registers the outputs once. Assumes DATA_W = 2 * byte width.
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_code,
    input  logic              is_word,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    input  logic [5:0]        flags_in,
    output logic [DATA_W-1:0] res_q,
    output logic              wr_en_q,
    output logic [5:0]        flags_q,
    output logic [5:0]        mask_q
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

    alu_op_e           op;
    logic [DATA_W-1:0] wmask, a_m, b_m;
    logic [DATA_W-1:0] add_a, add_b, add_sum;
    logic              add_cin, add_sub, add_cf, add_af, add_of;
    logic [DATA_W-1:0] dec_word;
    logic              dec_cf, dec_af;
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_we, stat_wide;
    logic [FLAG_N-1:0] core_flags, nxt_flags, nxt_mask;
    logic              st_pf, st_zf, st_sf;

    assign op = alu_op_e'(op_code);

    // Mask the operands to the selected width.
    always_comb begin
        wmask = is_word ? '1 : LOW_MASK;
        a_m   = opnd_a & wmask;
        b_m   = opnd_b & wmask;
    end

    // Steer operands and carry into the shared add/subtract core.
    always_comb begin
        add_a   = a_m;
        add_b   = b_m;
        add_cin = 1'b0;
        add_sub = 1'b0;
        case (op)
            OP_ADC:         add_cin = carry_in;
            OP_SUB, OP_CMP: add_sub = 1'b1;
            OP_SBB: begin
                add_sub = 1'b1;
                add_cin = carry_in;
            end
            OP_INC:         add_b = ONE;
            OP_DEC: begin
                add_b   = ONE;
                add_sub = 1'b1;
            end
            OP_NEG: begin
                add_a   = '0;
                add_b   = a_m;
                add_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a    (add_a),
        .b    (add_b),
        .cin  (add_cin),
        .sub  (add_sub),
        .wide (is_word),
        .sum  (add_sum),
        .cf   (add_cf),
        .af   (add_af),
        .of   (add_of)
    );

    alu_decimal_adj #(.HALF_W(HALF_W)) u_decimal (
        .lo_in    (opnd_a[HALF_W-1:0]),
        .hi_in    (opnd_a[DATA_W-1:HALF_W]),
        .af_in    (flags_in[FLG_AF]),
        .cf_in    (flags_in[FLG_CF]),
        .unpacked (op == OP_AAA),
        .word_out (dec_word),
        .cf_out   (dec_cf),
        .af_out   (dec_af)
    );

    // Choose the result, write-enable, operation-specific flags and mask.
    always_comb begin
        nxt_res    = add_sum;
        nxt_we     = 1'b1;
        core_flags = flags_in;
        nxt_mask   = '0;
        stat_wide  = is_word;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_NEG, OP_CMP: begin
                core_flags[FLG_CF] = add_cf;
                core_flags[FLG_AF] = add_af;
                core_flags[FLG_OF] = add_of;
                nxt_mask           = MASK_ALL;
                nxt_we             = (op != OP_CMP);
            end
            OP_INC, OP_DEC: begin
                core_flags[FLG_AF] = add_af;
                core_flags[FLG_OF] = add_of;
                nxt_mask           = MASK_KEEP_CF;
            end
            OP_AND, OP_OR, OP_XOR, OP_TEST: begin
                if (op == OP_OR)       nxt_res = a_m | b_m;
                else if (op == OP_XOR) nxt_res = a_m ^ b_m;
                else                   nxt_res = a_m & b_m;
                core_flags[FLG_CF] = 1'b0;
                core_flags[FLG_OF] = 1'b0;
                nxt_mask           = MASK_LOGIC;
                nxt_we             = (op != OP_TEST);
            end
            OP_NOT: nxt_res = ~a_m & wmask;
            OP_DAA, OP_AAA: begin
                nxt_res            = dec_word;
                core_flags[FLG_CF] = dec_cf;
                core_flags[FLG_AF] = dec_af;
                nxt_mask           = (op == OP_AAA) ? MASK_AAA : MASK_DAA;
                stat_wide          = 1'b0;
            end
            default: begin
                nxt_res = '0;
                nxt_we  = 1'b0;
            end
        endcase
    end

    alu_status #(.DATA_W(DATA_W)) u_status (
        .res  (nxt_res),
        .wide (stat_wide),
        .pf   (st_pf),
        .zf   (st_zf),
        .sf   (st_sf)
    );

    // Merge result-derived flags where the mask allows.
    always_comb begin
        nxt_flags = core_flags;
        if (nxt_mask[FLG_PF]) nxt_flags[FLG_PF] = st_pf;
        if (nxt_mask[FLG_ZF]) nxt_flags[FLG_ZF] = st_zf;
        if (nxt_mask[FLG_SF]) nxt_flags[FLG_SF] = st_sf;
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            wr_en_q <= 1'b0;
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            res_q   <= nxt_res;
            wr_en_q <= nxt_we;
            flags_q <= nxt_flags;
            mask_q  <= nxt_mask;
        end
    end

endmodule

// File: rtl/alu_flags_unit_chk.sv
// Property checker for alu_flags_unit, attached with bind. It relates the
// registered outputs to the inputs one clock earlier.
module alu_flags_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_code,
    input logic [5:0]        flags_in,
    input logic [DATA_W-1:0] res_q,
    input logic              wr_en_q,
    input logic [5:0]        flags_q,
    input logic [5:0]        mask_q
);
    // R3: increment and decrement keep the prior carry.
    a_r3_incdec_keeps_cf: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_code) == 4'd4 || $past(op_code) == 4'd5))
        |-> flags_q[0] == $past(flags_in[0]));

    // R5: logical ops clear carry and overflow.
    a_r5_logic_clears_cf_of: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) >= 4'd8 && $past(op_code) <= 4'd11)
        |-> (flags_q[0] == 1'b0 && flags_q[5] == 1'b0));

    // R6: compare and test write nothing.
    a_r6_cmp_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_code) == 4'd7 || $past(op_code) == 4'd11))
        |-> !wr_en_q);

    // R7: complement touches no flag.
    a_r7_not_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == 4'd12)
        |-> (mask_q == 6'b0 && flags_q == $past(flags_in)));

    // R2: an updated parity flag matches the low byte of the result.
    a_r2_parity_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[1] |-> flags_q[1] == ~^res_q[7:0]);

    // R12: flags outside the mask equal the prior flags.
    a_r12_unmasked_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_q ^ $past(flags_in)) & ~mask_q) == 6'b0);

endmodule

bind alu_flags_unit alu_flags_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_code  (op_code),
    .flags_in (flags_in),
    .res_q    (res_q),
    .wr_en_q  (wr_en_q),
    .flags_q  (flags_q),
    .mask_q   (mask_q)
);

// File: tb/alu_flags_unit_bench.sv
`timescale 1ns/100ps
module alu_flags_unit_bench;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        op_code = '0;
    logic              is_word = 1'b0;
    logic [DATA_W-1:0] opnd_a = '0;
    logic [DATA_W-1:0] opnd_b = '0;
    logic              carry_in = 1'b0;
    logic [5:0]        flags_in = '0;
    logic [DATA_W-1:0] res_q;
    logic              wr_en_q;
    logic [5:0]        flags_q;
    logic [5:0]        mask_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_flags_unit #(.DATA_W(DATA_W)) u_alu_flags_unit (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .is_word(is_word),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .flags_in(flags_in), .res_q(res_q), .wr_en_q(wr_en_q),
        .flags_q(flags_q), .mask_q(mask_q)
    );

    // Behavioural reference built from the requirements with plain integers.
    task automatic model(input int op, input bit wide, input int ain, input int bin,
                         input bit cin, input bit [5:0] fin,
                         output int r, output bit we, output bit [5:0] f,
                         output bit [5:0] msk);
        int w, m, a, b, x, y, ci, s, sw, al, ah, t;
        bit sub, keep, lo_fix, hi_fix, sx, sy, sr;
        w = wide ? 16 : 8;
        m = (1 << w) - 1;
        a = ain & m;
        b = bin & m;
        f = fin; msk = 6'b0; we = 1'b1; r = 0; sw = w;
        al = ain & 255; ah = (ain >> 8) & 255;
        if (op <= 7) begin
            x = a; y = b; ci = 0; sub = 0; keep = 0;
            if (op == 1) ci = cin;
            if (op == 2 || op == 7) sub = 1;
            if (op == 3) begin sub = 1; ci = cin; end
            if (op == 4) begin y = 1; keep = 1; end
            if (op == 5) begin y = 1; keep = 1; sub = 1; end
            if (op == 6) begin x = 0; y = a; sub = 1; end
            s = sub ? (x - y - ci) : (x + y + ci);
            r = s & m;
            sx = ((x >> (w-1)) & 1) != 0;
            sy = ((y >> (w-1)) & 1) != 0;
            sr = ((r >> (w-1)) & 1) != 0;
            if (!keep) f[0] = sub ? (s < 0) : (s > m);
            f[2] = (((x ^ y ^ s) >> 4) & 1) != 0;
            f[5] = sub ? (sx != sy && sr != sx) : (sx == sy && sr != sx);
            msk = keep ? 6'b111110 : 6'b111111;
            we = (op != 7);
        end else if (op <= 11) begin
            if (op == 9) r = a | b; else if (op == 10) r = a ^ b; else r = a & b;
            f[0] = 0; f[5] = 0; msk = 6'b111011; we = (op != 11);
        end else if (op == 12) begin
            r = ~a & m;
        end else if (op == 13) begin
            lo_fix = ((al & 15) > 9) || fin[2];
            hi_fix = (al > 'h99) || fin[0];
            t = (al + (lo_fix ? 6 : 0) + (hi_fix ? 'h60 : 0)) & 255;
            r = (ah << 8) | t;
            f[0] = hi_fix; f[2] = lo_fix; msk = 6'b011111; sw = 8;
        end else if (op == 14) begin
            lo_fix = ((al & 15) > 9) || fin[2];
            t = (al + (lo_fix ? 6 : 0)) & 15;
            r = (((ah + (lo_fix ? 1 : 0)) & 255) << 8) | t;
            f[0] = lo_fix; f[2] = lo_fix; msk = 6'b000101; sw = 8;
        end else begin
            we = 0;
        end
        if (msk[1]) f[1] = ($countones(r & 255) % 2) == 0;
        if (msk[3]) f[3] = (r & ((1 << sw) - 1)) == 0;
        if (msk[4]) f[4] = ((r >> (sw-1)) & 1) != 0;
    endtask

    task automatic spot(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one vector at a falling edge, then compare one clock later.
    task automatic run(input string tag, input int op, input bit wide, input int a,
                       input int b, input bit cin, input bit [5:0] fin);
        int er; bit ewe; bit [5:0] ef, em;
        op_code = op[3:0]; is_word = wide; opnd_a = a[15:0]; opnd_b = b[15:0];
        carry_in = cin; flags_in = fin;
        model(op, wide, a, b, cin, fin, er, ewe, ef, em);
        @(negedge clk);
        checks++;
        if (int'(res_q) != (er & 16'hFFFF) || wr_en_q != ewe || flags_q != ef || mask_q != em) begin
            errors++;
            $display("FAIL %s op=%0d: actual res=%h we=%b fl=%b mk=%b expected res=%h we=%b fl=%b mk=%b",
                     tag, op, res_q, wr_en_q, flags_q, mask_q, er[15:0], ewe, ef, em);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        spot("R1 reset res", int'(res_q), 0);
        spot("R1 reset ctl", int'({wr_en_q, flags_q, mask_q}), 0);
        rst_n = 1'b1;

        // R3: increment wraps with carry held
        run("R3", 4, 0, 'hFF, 0, 0, 6'b000001);
        spot("R3 inc FFh res", int'(res_q), 0);
        spot("R3 inc keeps CF", int'(flags_q[0]), 1);
        run("R3", 5, 1, 0, 0, 0, 6'b000000);
        spot("R3 dec 0 res", int'(res_q), 'hFFFF);
        spot("R3 dec keeps CF", int'(flags_q[0]), 0);

        // R4: borrow and carry-in
        run("R4", 2, 0, 5, 7, 0, 6'b0);
        spot("R4 sub borrow", int'(flags_q[0]), 1);
        run("R4", 3, 0, 7, 6, 1, 6'b0);
        spot("R4 sbb res", int'(res_q), 0);
        run("R4", 1, 1, 'hFFFF, 0, 1, 6'b0);
        spot("R4 adc carry", int'(flags_q[0]), 1);
        run("R4", 7, 1, 'h1234, 'h1235, 0, 6'b0);
        spot("R4 cmp borrow", int'(flags_q[0]), 1);

        // R5 and R6: logic clears CF/OF, keeps AF; compare/test write nothing
        run("R5", 8, 1, 'hF0F0, 'h0FF0, 0, 6'b111111);
        spot("R5 and keeps AF", int'(flags_q[2]), 1);
        spot("R5 and clears CF OF", int'({flags_q[5], flags_q[0]}), 0);
        run("R6", 11, 0, 'h80, 'h80, 0, 6'b0);
        spot("R6 test no write", int'(wr_en_q), 0);
        run("R6", 7, 0, 3, 3, 0, 6'b0);
        spot("R6 cmp no write zf", int'({wr_en_q, flags_q[3]}), 1);

        // R7: complement
        run("R7", 12, 0, 'h1234, 0, 0, 6'b101010);
        spot("R7 not res", int'(res_q), 'hCB);
        spot("R7 not flags", int'(flags_q), 6'b101010);

        // R8: negate minimum values
        run("R8", 6, 0, 'h80, 0, 0, 6'b0);
        spot("R8 neg 80h OF", int'(flags_q[5]), 1);
        run("R8", 6, 1, 'h8000, 0, 0, 6'b0);
        spot("R8 neg 8000h OF", int'({flags_q[5], flags_q[0]}), 3);
        run("R8", 6, 0, 0, 0, 0, 6'b0);
        spot("R8 neg 0 CF", int'(flags_q[0]), 0);

        // R9 and R10: decimal adjusts
        run("R9", 13, 0, 'h8E, 0, 0, 6'b0);
        spot("R9 daa 8Eh", int'(res_q), 'h94);
        run("R9", 13, 1, 'h12A0, 0, 0, 6'b0);
        spot("R9 daa hi fix", int'({res_q, flags_q[0]}), ('h1200 << 1) | 1);
        run("R10", 14, 0, 'h006E, 0, 0, 6'b0);
        spot("R10 aaa 6Eh", int'(res_q), 'h0104);
        spot("R10 aaa CF", int'(flags_q[0]), 1);
        run("R10", 14, 0, 'h0203, 0, 0, 6'b0);
        spot("R10 aaa no fix", int'({res_q, flags_q[0]}), 'h0203 << 1);

        // R11 and R2: overflow, nibble carry, width, parity on low byte
        run("R11", 0, 1, 'h7FFF, 1, 0, 6'b0);
        spot("R11 word OF SF", int'({flags_q[5], flags_q[4]}), 3);
        run("R11", 0, 0, 'h0F0F, 'h0101, 0, 6'b0);
        spot("R11 byte res AF", int'({res_q, flags_q[2]}), ('h0010 << 1) | 1);
        run("R2", 10, 1, 'hFF03, 0, 0, 6'b0);
        spot("R2 parity low byte", int'(flags_q[1]), 1);

        // R1: reserved op code
        run("R1", 15, 1, 'h1234, 'h4321, 1, 6'b110011);
        spot("R1 reserved", int'({wr_en_q, mask_q}), 0);

        // R12 and all ops: model comparison on mixed vectors
        for (int i = 0; i < 3000; i++) begin
            run("R12", int'($urandom_range(0, 15)), 1'($urandom), int'($urandom & 'hFFFF),
                int'($urandom & 'hFFFF), 1'($urandom), 6'($urandom));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule